// File: doc/BRIEF.md
# Multi-core run/stop controller

This block starts and halts the virtual processors (VPs) of a cluster under software control and reports which of them are running. Software writes a bit mask to a run register to start VPs and to a stop register to halt them. It reads a status register to see the current running mask. Each register can be reached at two address windows: one for the local core and one for another core. Both windows behave in exactly the same way.

A VP is started by sending it a one-cycle reset request. The VP is marked running only when it acknowledges that reset. A VP is stopped by sending it a one-cycle halt request, and its running bit clears at once. A run or stop command acts only on VPs whose state it would change. A stop that arrives while a start is still waiting for its acknowledge cancels that start. When the controller leaves reset, it starts the VPs named in a boot-mask parameter as if software had written that mask to the run register. A boot mask that names a VP which does not exist stops elaboration with an error.

Top module: `vpRunCtl`

## Requirements
- R1: Only data bits 0 to NUM_VP-1 of a run or stop write take part. Higher bits cause no reset request, no halt request and no status change.
- R2: A run write that selects a VP that is stopped and has no start waiting drives that VP's bit of `vpResetReq` high for exactly one cycle. This happens in the cycle after the write is accepted. The VP's running bit stays clear until it acknowledges.
- R3: A VP with a start waiting becomes running in the cycle after its `vpResetAck` bit is sampled high. An acknowledge from a VP with no start waiting has no effect.
- R4: A run write that selects a VP that is already running, or that already has a start waiting, produces no reset request and changes nothing for that VP.
- R5: A stop write that selects a running VP drives its bit of `vpHaltReq` high for one cycle and clears its running bit in the same cycle. A stop write that selects a stopped VP raises no halt request.
- R6: A stop write that selects a VP with a start waiting cancels that start without a halt request. A later acknowledge from that VP leaves it stopped.
- R7: `reqReady` is always high. Every accepted request is answered by `rspValid` high for one cycle, in the next cycle. For a status read, `rspRdata` holds the running mask, zero-extended to 64 bits, as it stood when the request was accepted. Bit i of the mask is VP i.
- R8: Within each window, the run register is at offset 0x00, the stop register at 0x08 and the status register at 0x10. The window bases are LOCAL_BASE (default 0x000) and OTHER_BASE (default 0x100). Both windows behave identically.
- R9: A write to any other address changes nothing. A read from any other address, and every write, returns `rspRdata` = 0.
- R10: During reset, all outputs are 0 and the running mask is 0. In the first cycle after reset is released, the VPs in BOOT_MASK are started exactly as by a run write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Register request present |
| reqReady | output | 1 | Request accepted (always 1) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address of the register |
| reqWdata | input | 64 | Write data (VP bit mask) |
| rspValid | output | 1 | Response strobe, one cycle after a request |
| rspRdata | output | 64 | Read data |
| vpResetReq | output | NUM_VP | One-cycle reset request per VP |
| vpResetAck | input | NUM_VP | Reset acknowledge per VP |
| vpHaltReq | output | NUM_VP | One-cycle halt request per VP |

## Verification
The hardest case to reach is a VP caught between its reset request and its acknowledge, while further run and stop writes arrive. Starts complete only when the environment answers. The bench therefore holds back `vpResetAck` for chosen VPs. While the acknowledge is held back, it repeats the run write and issues a stop through the other window. Only then does it send the late acknowledge, and it confirms that the running mask is unchanged. A behavioural model, kept cycle by cycle, tracks pending starts separately from running VPs. It checks every output on every clock, including stray acknowledges and data bits above the VP count.

// File: rtl/vprc_pkg.sv
package vprc_pkg;

  // Strobes from the address decoder to the VP datapath.
  typedef struct packed {
    logic accept;    // any request taken this cycle
    logic runWr;     // write to a run register (either window)
    logic stopWr;    // write to a stop register (either window)
    logic statusRd;  // read of a status register (either window)
  } vprcStrobe_t;

  // Mask of valid VP bits for a given VP count.
  function automatic logic [63:0] vpValidMask(input int unsigned numVp);
    logic [63:0] m;
    m = '0;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < numVp) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/vprc_decode.sv
module vprc_decode
  import vprc_pkg::*;
#(
  parameter int unsigned     ADDR_W     = 12,
  parameter logic [11:0]     LOCAL_BASE = 12'h000,
  parameter logic [11:0]     OTHER_BASE = 12'h100,
  parameter logic [11:0]     RUN_OFS    = 12'h000,
  parameter logic [11:0]     STOP_OFS   = 12'h008,
  parameter logic [11:0]     STAT_OFS   = 12'h010
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output vprcStrobe_t       strobe
);

  localparam int unsigned NUM_WIN = 2;

  logic [NUM_WIN-1:0] runHit;
  logic [NUM_WIN-1:0] stopHit;
  logic [NUM_WIN-1:0] statHit;

  // One comparator set per aliased window.
  for (genvar w = 0; w < NUM_WIN; w++) begin : gWin
    localparam logic [11:0] wBase = (w == 0) ? LOCAL_BASE : OTHER_BASE;
    localparam logic [ADDR_W-1:0] aRun  = ADDR_W'(wBase + RUN_OFS);
    localparam logic [ADDR_W-1:0] aStop = ADDR_W'(wBase + STOP_OFS);
    localparam logic [ADDR_W-1:0] aStat = ADDR_W'(wBase + STAT_OFS);
    assign runHit[w]  = (reqAddr == aRun);
    assign stopHit[w] = (reqAddr == aStop);
    assign statHit[w] = (reqAddr == aStat);
  end

  always_comb begin
    strobe          = '0;
    strobe.accept   = reqValid;
    strobe.runWr    = reqValid &  reqWrite & (|runHit);
    strobe.stopWr   = reqValid &  reqWrite & (|stopHit);
    strobe.statusRd = reqValid & ~reqWrite & (|statHit);
  end

endmodule

// File: rtl/vprc_datapath.sv
module vprc_datapath
  import vprc_pkg::*;
#(
  parameter int unsigned NUM_VP    = 1,
  parameter logic [63:0] BOOT_MASK = 64'h1
) (
  input  logic              clk,
  input  logic              rstN,
  input  vprcStrobe_t       strobe,
  input  logic [63:0]       reqWdata,
  input  logic [NUM_VP-1:0] vpResetAck,
  output logic [NUM_VP-1:0] vpResetReq,
  output logic [NUM_VP-1:0] vpHaltReq,
  output logic [NUM_VP-1:0] runningMask,
  output logic [NUM_VP-1:0] pendingMask,
  output logic              rspValid,
  output logic [63:0]       rspRdata
);

  localparam logic [63:0] VALID = vpValidMask(NUM_VP);

  logic              bootArm;
  logic [63:0]       maskedData;
  logic [NUM_VP-1:0] runSel;
  logic [NUM_VP-1:0] stopSel;
  logic [63:0]       statusWord;

  assign maskedData = reqWdata & VALID;

  always_comb begin
    runSel  = '0;
    stopSel = '0;
    if (strobe.runWr)  runSel  = maskedData[NUM_VP-1:0];
    if (bootArm)       runSel  = runSel | BOOT_MASK[NUM_VP-1:0];
    if (strobe.stopWr) stopSel = maskedData[NUM_VP-1:0];
  end

  // Boot policy fires once, in the first cycle out of reset.
  always_ff @(posedge clk) begin
    if (!rstN) bootArm <= 1'b1;
    else       bootArm <= 1'b0;
  end

  // Per-VP start/stop state.
  for (genvar i = 0; i < NUM_VP; i++) begin : gVp
    logic startNow;
    logic stopRun;
    logic ackTaken;

    assign startNow = runSel[i] & ~stopSel[i] & ~runningMask[i] & ~pendingMask[i];
    assign stopRun  = stopSel[i] & runningMask[i];
    assign ackTaken = pendingMask[i] & vpResetAck[i] & ~stopSel[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        runningMask[i] <= 1'b0;
        pendingMask[i] <= 1'b0;
        vpResetReq[i]  <= 1'b0;
        vpHaltReq[i]   <= 1'b0;
      end else begin
        vpResetReq[i]  <= startNow;
        vpHaltReq[i]   <= stopRun;
        pendingMask[i] <= startNow | (pendingMask[i] & ~vpResetAck[i] & ~stopSel[i]);
        runningMask[i] <= (runningMask[i] & ~stopSel[i]) | ackTaken;
      end
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[NUM_VP-1:0] = runningMask;
  end

  // Registered response path.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= strobe.accept;
      rspRdata <= strobe.statusRd ? statusWord : 64'd0;
    end
  end

endmodule

// File: rtl/vpRunCtl.sv
module vpRunCtl
  import vprc_pkg::*;
#(
  parameter int unsigned NUM_VP     = 1,
  parameter logic [63:0] BOOT_MASK  = 64'h1,
  parameter int unsigned ADDR_W     = 12,
  parameter logic [11:0] LOCAL_BASE = 12'h000,
  parameter logic [11:0] OTHER_BASE = 12'h100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [63:0]       reqWdata,
  output logic              rspValid,
  output logic [63:0]       rspRdata,
  output logic [NUM_VP-1:0] vpResetReq,
  input  logic [NUM_VP-1:0] vpResetAck,
  output logic [NUM_VP-1:0] vpHaltReq
);

  localparam logic [63:0] VALID = vpValidMask(NUM_VP);

  if ((BOOT_MASK & ~VALID) != 64'd0) begin : gBadBoot
    $error("vpRunCtl: BOOT_MASK names VPs beyond NUM_VP");
  end

  vprcStrobe_t       strobe;
  logic [NUM_VP-1:0] runningMask;
  logic [NUM_VP-1:0] pendingMask;

  assign reqReady = 1'b1;

  vprc_decode #(
    .ADDR_W    (ADDR_W),
    .LOCAL_BASE(LOCAL_BASE),
    .OTHER_BASE(OTHER_BASE),
    .RUN_OFS   (12'h000),
    .STOP_OFS  (12'h008),
    .STAT_OFS  (12'h010)
  ) decode_i (
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .strobe  (strobe)
  );

  vprc_datapath #(
    .NUM_VP   (NUM_VP),
    .BOOT_MASK(BOOT_MASK)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqWdata   (reqWdata),
    .vpResetAck (vpResetAck),
    .vpResetReq (vpResetReq),
    .vpHaltReq  (vpHaltReq),
    .runningMask(runningMask),
    .pendingMask(pendingMask),
    .rspValid   (rspValid),
    .rspRdata   (rspRdata)
  );

endmodule

// File: rtl/vprc_checker.sv
module vprc_checker #(
  parameter int unsigned NUM_VP = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              rspValid,
  input logic [63:0]       rspRdata,
  input logic [NUM_VP-1:0] vpResetReq,
  input logic [NUM_VP-1:0] vpResetAck,
  input logic [NUM_VP-1:0] vpHaltReq,
  input logic [NUM_VP-1:0] runningMask,
  input logic [NUM_VP-1:0] pendingMask
);

  // R2: reset request never lasts two cycles
  assert_reset_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|vpResetReq) |=> ((vpResetReq & $past(vpResetReq)) == '0));

  // R3: a VP only becomes running after an acknowledge while pending
  assert_run_on_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((runningMask & ~$past(runningMask)) & ~($past(pendingMask) & $past(vpResetAck))) == '0);

  // R4: a VP is never both waiting to start and running
  assert_pend_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pendingMask & runningMask) == '0);

  // R5: halt only goes to VPs that were running, which are now stopped
  assert_halt_running_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|vpHaltReq) |-> (((vpHaltReq & ~$past(runningMask)) == '0) && ((vpHaltReq & runningMask) == '0)));

  // R7: every accepted request gets a response next cycle
  assert_resp_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R9: write responses carry zero data
  assert_write_rsp_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> (rspRdata == 64'd0));

endmodule

bind vpRunCtl vprc_checker #(.NUM_VP(NUM_VP)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqWrite   (reqWrite),
  .rspValid   (rspValid),
  .rspRdata   (rspRdata),
  .vpResetReq (vpResetReq),
  .vpResetAck (vpResetAck),
  .vpHaltReq  (vpHaltReq),
  .runningMask(runningMask),
  .pendingMask(pendingMask)
);

// File: tb/vpRunCtl_tb_top.sv
module vpRunCtl_tb_top;

  localparam int unsigned NV    = 4;
  localparam logic [63:0] BOOT  = 64'h5;
  localparam logic [11:0] LB    = 12'h000;
  localparam logic [11:0] OB    = 12'h100;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [11:0]   reqAddr = '0;
  logic [63:0]   reqWdata = '0;
  logic          rspValid;
  logic [63:0]   rspRdata;
  logic [NV-1:0] vpResetReq;
  logic [NV-1:0] vpResetAck = '0;
  logic [NV-1:0] vpHaltReq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  string phase = "R10";

  always #10 clk = ~clk;  // 50 MHz

  vpRunCtl #(
    .NUM_VP(NV), .BOOT_MASK(BOOT), .ADDR_W(12), .LOCAL_BASE(LB), .OTHER_BASE(OB)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .vpResetReq(vpResetReq),
    .vpResetAck(vpResetAck), .vpHaltReq(vpHaltReq)
  );

  // Behavioural reference model
  bit        mBoot;
  bit [NV-1:0] mRun, mPend, mRst, mHalt;
  bit        mRspV;
  bit [63:0] mRd;

  always @(posedge clk) begin
    bit [NV-1:0] runB, stopB, nRun, nPend, nRst, nHalt;
    bit [63:0] rdv;
    if (!rstN) begin
      mBoot = 1; mRun = '0; mPend = '0; mRst = '0; mHalt = '0; mRspV = 0; mRd = '0;
    end else begin
      runB = mBoot ? BOOT[NV-1:0] : '0;
      mBoot = 0;
      stopB = '0;
      rdv = '0;
      if (reqValid && reqWrite && (reqAddr == LB || reqAddr == OB))
        runB = runB | reqWdata[NV-1:0];
      if (reqValid && reqWrite && (reqAddr == LB + 12'h8 || reqAddr == OB + 12'h8))
        stopB = reqWdata[NV-1:0];
      if (reqValid && !reqWrite && (reqAddr == LB + 12'h10 || reqAddr == OB + 12'h10))
        rdv = 64'(mRun);
      for (int i = 0; i < NV; i++) begin
        bit st;
        st = runB[i] && !stopB[i] && !mRun[i] && !mPend[i];
        nRst[i]  = st;
        nHalt[i] = stopB[i] && mRun[i];
        nPend[i] = st || (mPend[i] && !vpResetAck[i] && !stopB[i]);
        nRun[i]  = (mRun[i] || (mPend[i] && vpResetAck[i])) && !stopB[i];
      end
      mRun = nRun; mPend = nPend; mRst = nRst; mHalt = nHalt;
      mRspV = reqValid; mRd = rdv;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished && $time > 15) begin
      check(vpResetReq === mRst,  phase, "vpResetReq", 64'(vpResetReq), 64'(mRst));
      check(vpHaltReq  === mHalt, phase, "vpHaltReq",  64'(vpHaltReq),  64'(mHalt));
      check(rspValid   === mRspV, phase, "rspValid",   64'(rspValid),   64'(mRspV));
      check(rspRdata   === mRd,   phase, "rspRdata",   rspRdata,        mRd);
      check(reqReady   === 1'b1,  "R7", "reqReady",    64'(reqReady),   64'd1);
    end
  end

  task automatic busOp(input bit wr, input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 0; reqWrite = 0; reqAddr = '0; reqWdata = '0;
  endtask

  task automatic readCheck(input logic [11:0] a, input logic [63:0] exp, input string tag);
    busOp(0, a, '0);
    check(rspValid === 1'b1, tag, "read rspValid", 64'(rspValid), 64'd1);
    check(rspRdata === exp,  tag, "read data",     rspRdata,      exp);
  endtask

  task automatic ack(input logic [NV-1:0] b);
    @(negedge clk); vpResetAck = b;
    @(negedge clk); vpResetAck = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs quiet in reset
    check(vpResetReq === '0 && vpHaltReq === '0 && rspValid === 0, "R10", "reset outputs",
          64'(vpResetReq), 64'd0);
    rstN = 1;
    @(negedge clk);
    check(vpResetReq === 4'h5, "R10", "boot reset request", 64'(vpResetReq), 64'h5);
    readCheck(LB + 12'h10, 64'h0, "R2");     // not running before ack
    ack(4'h5);
    readCheck(LB + 12'h10, 64'h5, "R10");

    phase = "R1";                            // high data bits ignored, VP1 started via other window
    busOp(1, OB + 12'h0, 64'hFFFF_FFFF_FFFF_FFF2);
    check(vpResetReq === 4'h2, "R2", "run pulse VP1", 64'(vpResetReq), 64'h2);
    phase = "R4";
    busOp(1, LB + 12'h0, 64'h7);             // VP0/2 running, VP1 pending
    check(vpResetReq === 4'h0, "R4", "no reset on busy VPs", 64'(vpResetReq), 64'h0);
    phase = "R3";
    ack(4'h2);
    readCheck(OB + 12'h10, 64'h7, "R8");

    phase = "R5";
    busOp(1, LB + 12'h8, 64'h1);
    check(vpHaltReq === 4'h1, "R5", "halt VP0", 64'(vpHaltReq), 64'h1);
    readCheck(LB + 12'h10, 64'h6, "R5");
    busOp(1, OB + 12'h8, 64'h1);
    check(vpHaltReq === 4'h0, "R5", "no halt on stopped VP", 64'(vpHaltReq), 64'h0);

    phase = "R6";
    busOp(1, LB + 12'h0, 64'h8);
    idle(2);
    busOp(1, OB + 12'h8, 64'h8);
    check(vpHaltReq === 4'h0, "R6", "no halt on pending cancel", 64'(vpHaltReq), 64'h0);
    ack(4'h8);
    readCheck(LB + 12'h10, 64'h6, "R6");

    phase = "R3";                            // stray ack on stopped VP0
    ack(4'h1);
    readCheck(LB + 12'h10, 64'h6, "R3");

    phase = "R9";
    busOp(1, LB + 12'h18, 64'hF);
    busOp(1, 12'h200, 64'hF);
    check(vpResetReq === 4'h0 && vpHaltReq === 4'h0, "R9", "unknown write quiet",
          64'(vpResetReq | vpHaltReq), 64'h0);
    readCheck(LB + 12'h18, 64'h0, "R9");
    readCheck(OB + 12'h10, 64'h6, "R9");

    phase = "R1";
    busOp(1, LB + 12'h8, 64'hFFFF_FFFF_FFFF_FFF0);
    check(vpHaltReq === 4'h0, "R1", "high stop bits ignored", 64'(vpHaltReq), 64'h0);
    readCheck(OB + 12'h10, 64'h6, "R1");

    phase = "R8";                            // restart VP0 via other window, ack, stop VP1 and VP2 via other
    busOp(1, OB + 12'h0, 64'h1);
    ack(4'h1);
    busOp(1, OB + 12'h8, 64'h6);
    check(vpHaltReq === 4'h6, "R8", "halt via other window", 64'(vpHaltReq), 64'h6);
    readCheck(LB + 12'h10, 64'h1, "R8");

    idle(3);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired in phase %s actual=timeout expected=done", phase);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule